// File: doc/BRIEF.md
# Triplexed LCD Segment Multiplexer

This block drives a three-backplane multiplexed seven-segment liquid crystal display. The display shows four full digits, a leading half digit that can only show "1", a minus sign, four decimal points and two status flags (low battery and continuity). It takes the latched BCD digit codes and the flag inputs of a measurement front end. It produces three backplane lines, twelve segment lines and one annunciator line. Each line is given as a 2-bit drive-level code for a four-level, 1/3-bias scheme. An analog stage outside the block turns the codes into voltages.

A frame timer divides the system clock into six equal phases. Each backplane is active for two consecutive phases of opposite polarity, so every segment sees zero net DC over a frame. Each segment line carries three segments, one per backplane. In each phase the block puts every line at the level that lights or darkens the segment that belongs to the active backplane. The annunciator line always sits at the "on" extreme of the current phase. An annunciator wired to it is therefore lit, and one wired to its own backplane stays dark.

The frame timer is a state machine with six states, visited in the fixed order S1_POS → S1_NEG → S2_POS → S2_NEG → S3_POS → S3_NEG → S1_POS. S1, S2 and S3 name the active backplane, and POS and NEG name the polarity half. Each transition is an ADVANCE, which fires when the prescaler has counted `PHASE_TICKS` clocks. Reset enters S1_POS.

Top module: `lcd3_mux`

## Requirements
- R1: During and straight after reset the block is in S1_POS: backplane 1 code 3, backplanes 2 and 3 code 1, annunciator code 0.
- R2: Each phase lasts exactly PHASE_TICKS = CLK_HZ/(FRAME_HZ*6) clocks. The phases run in the order S1_POS, S1_NEG, S2_POS, S2_NEG, S3_POS, S3_NEG and then repeat.
- R3: Level codes are 0 = display rail, 1 = one third, 2 = two thirds, 3 = positive rail. The active backplane is 3 in a POS phase and 0 in a NEG phase. Idle backplanes are 1 in POS and 2 in NEG. `bp_code[2b+1:2b]` is backplane b+1.
- R4: A segment line whose segment on the active backplane is lit is 0 in POS and 3 in NEG. A line whose segment is dark is 2 in POS and 1 in NEG.
- R5: The annunciator line is 0 in every POS phase and 3 in every NEG phase.
- R6: Digit n (n = 1..4, digit 4 most significant) owns lines 3(n-1), 3(n-1)+1 and 3(n-1)+2 (`seg_code[2L+1:2L]` is line L). Their segments on backplanes 1/2/3 are B/C/extra, A/G/D and F/E/decimal point n, in that order.
- R7: On digit 4 the middle line carries A/D/G on backplanes 1/2/3.
- R8: The extra segment is continuity on digit 1, low battery on digit 2, minus on digit 3, and the half digit's B+C pair on digit 4.
- R9: BCD codes 0–9 show the usual seven-segment glyphs (segment bits a..g: 0→3F, 1→06, 2→5B, 3→4F, 4→66, 5→6D, 6→7D, 7→07, 8→7F, 9→6F, bit 0 = a). Codes 10–15 leave the digit blank.
- R10: While `over_range` is high, segments A–G of digits 1–4 are dark. The decimal points, the minus sign, both flags and the half digit are not affected.
- R11: With the inputs held, every segment line in a NEG phase carries the bitwise inverse (3 − code) of its code in the POS phase of the same backplane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_bcd | input | 16 | BCD digits; [3:0] is digit 1 (least significant) |
| lead_one | input | 1 | Half digit shows "1" |
| minus_sign | input | 1 | Minus sign lit |
| dp_en | input | 4 | Decimal point enables; bit n-1 for digit n |
| over_range | input | 1 | Blank digits 1–4 |
| low_batt | input | 1 | Low-battery flag lit |
| cont_flag | input | 1 | Continuity flag lit |
| bp_code | output | 6 | Backplane level codes, 2 bits each |
| seg_code | output | 24 | Segment line level codes, 2 bits each |
| ann_code | output | 2 | Annunciator level code |

## Verification
The hardest case to reach is the three-way pixel mapping. A line is correct only if the segment for each backplane appears in the right phase. A fault in one slot shows up only in the two phases of one backplane, and only for an input pattern that lights that segment and not its neighbours on the same line. The stimulus therefore runs whole frames with contrasting patterns: a mixed digit pattern, all segments and flags lit, overrange with every flag lit, out-of-range BCD codes, and single flags on their own. Every frame is sampled at both the first and the last clock of each of its six phases, so a phase that is too long or too short, or that comes in the wrong order, is also caught.

// File: rtl/lcd3_pkg.sv
package lcd3_pkg;

    localparam int N_DIGITS = 4;
    localparam int N_BP     = 3;
    localparam int N_LINES  = N_DIGITS * N_BP;
    localparam int N_PHASES = 2 * N_BP;

    // Drive levels of the 1/3-bias scheme
    typedef enum logic [1:0] {
        LV_RAIL_LO = 2'd0,
        LV_MID_LO  = 2'd1,
        LV_MID_HI  = 2'd2,
        LV_RAIL_HI = 2'd3
    } lvl_e;

    typedef enum logic [2:0] {
        S1_POS, S1_NEG, S2_POS, S2_NEG, S3_POS, S3_NEG
    } phase_e;

    // Segment bit order: bit 0 = a ... bit 6 = g
    function automatic logic [6:0] bcd_to_seg(input logic [3:0] v);
        logic [6:0] s;
        case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lcd3_frame_timer.sv
module lcd3_frame_timer
    import lcd3_pkg::*;
#(
    parameter int PHASE_TICKS = 100
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [N_BP-1:0] slot_oh,
    output logic            neg_half
);

    localparam int            CW   = $clog2(PHASE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

    phase_e        state, state_nx;
    logic [CW-1:0] tick_cnt;

    // State register with phase prescaler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S1_POS;
            tick_cnt <= '0;
        end else if (tick_cnt == LAST) begin
            state    <= state_nx;
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Next phase and phase outputs
    always_comb begin
        state_nx = S1_POS;
        slot_oh  = 3'b001;
        neg_half = 1'b0;
        unique case (state)
            S1_POS: begin state_nx = S1_NEG; slot_oh = 3'b001; neg_half = 1'b0; end
            S1_NEG: begin state_nx = S2_POS; slot_oh = 3'b001; neg_half = 1'b1; end
            S2_POS: begin state_nx = S2_NEG; slot_oh = 3'b010; neg_half = 1'b0; end
            S2_NEG: begin state_nx = S3_POS; slot_oh = 3'b010; neg_half = 1'b1; end
            S3_POS: begin state_nx = S3_NEG; slot_oh = 3'b100; neg_half = 1'b0; end
            S3_NEG: begin state_nx = S1_POS; slot_oh = 3'b100; neg_half = 1'b1; end
            default: begin state_nx = S1_POS; slot_oh = 3'b001; neg_half = 1'b0; end
        endcase
    end

endmodule

// File: rtl/lcd3_seg_map.sv
module lcd3_seg_map
    import lcd3_pkg::*;
(
    input  logic [4*N_DIGITS-1:0]           digit_bcd,
    input  logic                            lead_one,
    input  logic                            minus_sign,
    input  logic [N_DIGITS-1:0]             dp_en,
    input  logic                            over_range,
    input  logic                            low_batt,
    input  logic                            cont_flag,
    output logic [N_LINES-1:0][N_BP-1:0]    seg_on
);

    // Extra segment of each digit's B/C line
    logic [N_DIGITS-1:0] extra;
    assign extra = {lead_one, minus_sign, low_batt, cont_flag};

    for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
        logic [6:0] sg;
        assign sg = over_range ? 7'h00 : bcd_to_seg(digit_bcd[4*d +: 4]);

        // index inside each triple = backplane (0 = first)
        assign seg_on[3*d]     = {extra[d], sg[2], sg[1]};
        if (d == N_DIGITS - 1) begin : g_top
            assign seg_on[3*d + 1] = {sg[6], sg[3], sg[0]};
        end else begin : g_low
            assign seg_on[3*d + 1] = {sg[3], sg[6], sg[0]};
        end
        assign seg_on[3*d + 2] = {dp_en[d], sg[4], sg[5]};
    end

endmodule

// File: rtl/lcd3_level_drive.sv
module lcd3_level_drive
    import lcd3_pkg::*;
(
    input  logic [N_LINES-1:0][N_BP-1:0] seg_on,
    input  logic [N_BP-1:0]              slot_oh,
    input  logic                         neg_half,
    output logic [2*N_BP-1:0]            bp_code,
    output logic [2*N_LINES-1:0]         seg_code,
    output logic [1:0]                   ann_code
);

    for (genvar b = 0; b < N_BP; b++) begin : g_bp
        assign bp_code[2*b +: 2] = slot_oh[b]
            ? (neg_half ? LV_RAIL_LO : LV_RAIL_HI)
            : (neg_half ? LV_MID_HI  : LV_MID_LO);
    end

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        logic lit;
        assign lit = |(seg_on[l] & slot_oh);
        assign seg_code[2*l +: 2] = lit
            ? (neg_half ? LV_RAIL_HI : LV_RAIL_LO)
            : (neg_half ? LV_MID_LO  : LV_MID_HI);
    end

    assign ann_code = neg_half ? LV_RAIL_HI : LV_RAIL_LO;

endmodule

// File: rtl/lcd3_mux.sv
module lcd3_mux
    import lcd3_pkg::*;
#(
    parameter int CLK_HZ   = 60000,
    parameter int FRAME_HZ = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4*N_DIGITS-1:0]   digit_bcd,
    input  logic                    lead_one,
    input  logic                    minus_sign,
    input  logic [N_DIGITS-1:0]     dp_en,
    input  logic                    over_range,
    input  logic                    low_batt,
    input  logic                    cont_flag,
    output logic [2*N_BP-1:0]       bp_code,
    output logic [2*N_LINES-1:0]    seg_code,
    output logic [1:0]              ann_code
);

    localparam int PHASE_TICKS = CLK_HZ / (FRAME_HZ * N_PHASES);

    logic [N_BP-1:0]              slot_oh;
    logic                         neg_half;
    logic [N_LINES-1:0][N_BP-1:0] seg_on;

    lcd3_frame_timer #(.PHASE_TICKS(PHASE_TICKS)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_oh  (slot_oh),
        .neg_half (neg_half)
    );

    lcd3_seg_map i_map (
        .digit_bcd  (digit_bcd),
        .lead_one   (lead_one),
        .minus_sign (minus_sign),
        .dp_en      (dp_en),
        .over_range (over_range),
        .low_batt   (low_batt),
        .cont_flag  (cont_flag),
        .seg_on     (seg_on)
    );

    lcd3_level_drive i_drive (
        .seg_on   (seg_on),
        .slot_oh  (slot_oh),
        .neg_half (neg_half),
        .bp_code  (bp_code),
        .seg_code (seg_code),
        .ann_code (ann_code)
    );

endmodule

// File: rtl/lcd3_mux_chk.sv
module lcd3_mux_chk #(
    parameter int PHASE_TICKS = 100
) (
    input logic        clk,
    input logic        rst_n,
    input logic [24:0] in_bus,
    input logic [5:0]  bp_code,
    input logic [23:0] seg_code,
    input logic [1:0]  ann_code
);

    logic [2:0]  act_oh;
    logic [1:0]  act_lvl;
    logic        neg;
    logic [11:0] seg_lsb;

    always_comb begin
        act_lvl = 2'd0;
        for (int b = 0; b < 3; b++) begin
            act_oh[b] = (bp_code[2*b +: 2] == 2'd0) || (bp_code[2*b +: 2] == 2'd3);
            if (act_oh[b]) act_lvl = bp_code[2*b +: 2];
        end
        for (int l = 0; l < 12; l++) seg_lsb[l] = seg_code[2*l];
        neg = (act_lvl == 2'd0);
    end

    // Run length of the current backplane pattern
    logic [5:0] last_bp;
    int         since;
    always_ff @(posedge clk) begin
        last_bp <= bp_code;
        if (!rst_n)                  since <= 0;
        else if (bp_code != last_bp) since <= 1;
        else if (since < PHASE_TICKS + 1) since <= since + 1;
    end

    assert_one_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_oh) == 1);

    assert_ann_opposite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ann_code == ~act_lvl);

    assert_seg_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_lsb == {12{neg}});

    assert_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_code != last_bp) |-> (since == PHASE_TICKS));

    assert_phase_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        since <= PHASE_TICKS);

    assert_same_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(neg) |-> $stable(act_oh));

    assert_slot_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(neg) |-> (act_oh == {$past(act_oh[1:0]), $past(act_oh[2])}));

    assert_dc_balance_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(neg) && $stable(in_bus)) |-> (seg_code == ~$past(seg_code)));

endmodule

bind lcd3_mux lcd3_mux_chk #(.PHASE_TICKS(PHASE_TICKS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_bus   ({digit_bcd, lead_one, minus_sign, dp_en, over_range, low_batt, cont_flag}),
    .bp_code  (bp_code),
    .seg_code (seg_code),
    .ann_code (ann_code)
);

// File: tb/test_lcd3_mux.sv
module test_lcd3_mux;

    localparam int PT = 4;  // 24 Hz / (1 Hz * 6)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dg = '0;
    logic        lead = 1'b0, mn = 1'b0, ov = 1'b0, lb = 1'b0, ct = 1'b0;
    logic [3:0]  dp = '0;
    logic [5:0]  bp_code;
    logic [23:0] seg_code;
    logic [1:0]  ann_code;

    always #10 clk = ~clk;  // 50 MHz

    lcd3_mux #(.CLK_HZ(24), .FRAME_HZ(1)) i_lcd3_mux (
        .clk(clk), .rst_n(rst_n), .digit_bcd(dg), .lead_one(lead),
        .minus_sign(mn), .dp_en(dp), .over_range(ov), .low_batt(lb),
        .cont_flag(ct), .bp_code(bp_code), .seg_code(seg_code), .ann_code(ann_code)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;   // {ann, seg, bp}
        int          ph;
        string       tag;
    } item_t;
    item_t q[$];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    function automatic logic [6:0] glyph(input logic [3:0] v);
        logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                               7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return (v < 10) ? t[v] : 7'h00;
    endfunction

    // Expected drive codes for phase ph, from the requirements
    function automatic logic [31:0] model(input int ph);
        int slot = ph / 2;
        bit ng = (ph % 2) == 1;
        logic [5:0]  b = '0;
        logic [23:0] s = '0;
        logic [3:0]  xf = {lead, mn, lb, ct};                  // R8
        for (int i = 0; i < 3; i++)                             // R3
            b[2*i +: 2] = (i == slot) ? (ng ? 2'd0 : 2'd3) : (ng ? 2'd2 : 2'd1);
        for (int n = 0; n < 4; n++) begin
            logic [6:0] p = ov ? 7'h00 : glyph(dg[4*n +: 4]);  // R9, R10
            bit on [3][3];
            on[0] = '{p[1], p[2], xf[n]};                       // B C x
            if (n == 3) on[1] = '{p[0], p[3], p[6]};            // R7: A D G
            else        on[1] = '{p[0], p[6], p[3]};            // R6: A G D
            on[2] = '{p[5], p[4], dp[n]};                       // F E DP
            for (int k = 0; k < 3; k++)                         // R4
                s[2*(3*n+k) +: 2] = on[k][slot] ? (ng ? 2'd3 : 2'd0) : (ng ? 2'd1 : 2'd2);
        end
        return {(ng ? 2'd3 : 2'd0), s, b};                      // R5
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual ann=%h seg=%h bp=%h expected ann=%h seg=%h bp=%h",
                     tag, act[31:30], act[29:6], act[5:0], exp[31:30], exp[29:6], exp[5:0]);
        end
    endtask

    // Driver: applies one pattern for a whole frame and queues its six phases
    task automatic drive_frame(input logic [15:0] d, input logic l, input logic m,
                               input logic [3:0] p, input logic o, input logic b,
                               input logic c, input string tag);
        do @(negedge clk); while (!((cyc % PT) == PT - 1 && ((cyc / PT) % 6) == 5));
        #2;
        dg = d; lead = l; mn = m; dp = p; ov = o; lb = b; ct = c;
        for (int ph = 0; ph < 6; ph++) q.push_back('{model(ph), ph, tag});
    endtask

    // Monitor: first and last clock of each phase (R2 timing, R11 balance)
    always @(negedge clk) begin
        if (rst_n && q.size() > 0 && q[0].ph == (cyc / PT) % 6) begin
            if (cyc % PT == 0)
                check({q[0].tag, " R2 phase start"}, {ann_code, seg_code, bp_code}, q[0].exp);
            else if (cyc % PT == PT - 1) begin
                check({q[0].tag, " R2 phase end"}, {ann_code, seg_code, bp_code}, q[0].exp);
                void'(q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        dg = 16'h4321;
        repeat (3) @(negedge clk);
        // R1: reset state is S1_POS
        check("R1 reset", {ann_code, seg_code, bp_code}, model(0));
        check("R1 reset bp", {26'd0, bp_code}, {26'd0, 6'b01_01_11});
        rst_n = 1'b1;
        drive_frame(16'h4321, 0, 0, 4'h0, 0, 0, 0, "R6 R9 mixed");
        drive_frame(16'h8888, 1, 1, 4'hF, 0, 1, 1, "R6 R7 R8 all lit");
        drive_frame(16'h8888, 1, 1, 4'hF, 1, 1, 1, "R10 overrange");
        drive_frame(16'hFEDC, 0, 0, 4'h0, 0, 0, 0, "R9 invalid bcd");
        drive_frame(16'h7650, 0, 0, 4'h5, 0, 0, 0, "R9 R6 digits");
        drive_frame(16'h0009, 0, 0, 4'h0, 0, 0, 1, "R8 continuity");
        drive_frame(16'h1111, 0, 1, 4'h0, 0, 1, 0, "R8 lowbat minus");
        drive_frame(16'h2000, 1, 0, 4'h8, 1, 0, 0, "R10 R8 half digit");
        drive_frame(16'h0000, 0, 0, 4'h0, 0, 0, 0, "R11 zeros");
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule